// File: doc/BRIEF.md
# LR Clock Frame Sync Monitor

This block watches the bit clock and the LR (word/frame) clock that an external codec drives onto an audio serial port. The port runs as a slave, in either two-channel I2S or multi-slot TDM. The monitor samples both lines in the system clock domain. It locks to the frame by waiting for a fixed run of LR levels, and it then tracks the 32-bit slot position. At each slot boundary it compares the last 32 sampled LR bits against the pattern that slot should show. If the pattern is wrong, the bit clock has glitched or the frame has slipped. The monitor then raises a one-cycle error and hunts for the frame again.

Surrounding logic uses `in_sync_o` to gate data transfer and `slot_o` to steer samples to channels. The format is chosen with `tdm_mode_i`, which is read only while the monitor is hunting. The number of slots in a TDM frame is `TDM_CHANS / DATA_LINES`. An I2S frame always has two slots.

Top module: `lrclk_sync_monitor`

## Requirements
- R1: After reset, `in_sync_o` and `sync_err_o` are 0 and `slot_o` is 0.
- R2: In I2S mode (`tdm_mode_i`=0), the bit clock edge that counts is a rising edge, and each one samples the LR level. The monitor locks after it has seen the level sequence low, high, low, high, low. Each step is met by the first sampled bit at that level. Lock happens on the bit that completes the final low, and not earlier.
- R3: In TDM mode (`tdm_mode_i`=1), the monitor locks on the bit that shows the third low-to-high change of LR. A complete sequence low, high, low, high, low, high is needed before lock.
- R4: On every rising bit clock edge, the sampled LR bit enters a 32-bit window at bit 31, and older bits move toward bit 0. Between edges the window holds its value.
- R5: In I2S mode, the lock bit is frame position 0. A boundary check runs every 32 bits after that, and the first check falls 32 bits after lock. At a boundary entering slot 1, the window must be 0x80000000. At a boundary entering slot 0, it must be 0x7FFFFFFF.
- R6: In TDM mode, only the boundary entering slot 0 is checked. Window bits [31:30] must be 2'b10, which marks a rising frame-sync edge on the newest bit. The other window bits, and the width of the frame-sync pulse, do not matter.
- R7: A failed check produces a `sync_err_o` pulse exactly one cycle long. In that same cycle `in_sync_o` drops and `slot_o` returns to 0. The lock sequence then restarts from its first step, and the monitor relocks to a clean stream.
- R8: While locked, `slot_o` is 0 on the lock bit and advances by one every 32 bits. It wraps after 1 in I2S mode and after `TDM_CHANS/DATA_LINES - 1` in TDM mode.
- R9: The format chosen by `tdm_mode_i` is captured at lock. Changes to the input while locked have no effect until the next hunt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | External serial bit clock |
| lrclk_i | input | 1 | External LR / frame-sync clock |
| tdm_mode_i | input | 1 | 0 = I2S, 1 = TDM; read while hunting |
| in_sync_o | output | 1 | High while locked to the frame |
| sync_err_o | output | 1 | One-cycle pulse when a slot check fails |
| slot_o | output | $clog2(max(TDM_CHANS/DATA_LINES,2)) | Current slot index within the frame |

## Verification
The assertions rely on a few properties of the inputs:
- Each half-period of the bit clock spans at least two system clock cycles, so two detected rising edges can never fall in adjacent cycles.
- LR changes only while the bit clock is low, so the sampled LR bit is stable at each detected edge.

The stimulus holds the bit clock low for four cycles and high for four, and it changes LR only at the start of the low phase. Faults are injected as whole extra bits, never as sub-bit glitches, so every fault is a clean frame slip that the slot checks are required to catch.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    localparam int WIN_W = 32;

    localparam logic [WIN_W-1:0] I2S_ENTER_SLOT1 = 32'h8000_0000;
    localparam logic [WIN_W-1:0] I2S_ENTER_SLOT0 = 32'h7FFF_FFFF;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_RUN  = 1'b1
    } lsm_state_e;

    typedef struct packed {
        logic tick;   // rising bit clock edge detected this cycle
        logic lr;     // LR level sampled with that edge
    } lsm_bit_t;

    // Index of the final step in the lock level sequence
    function automatic logic [2:0] hunt_last_step(input logic tdm);
        return tdm ? 3'd5 : 3'd4;
    endfunction

    // Boundary check on the window that includes the newest bit
    function automatic logic window_ok(input logic tdm,
                                       input logic entering_slot0,
                                       input logic [WIN_W-1:0] win);
        if (tdm)
            return !entering_slot0 || (win[WIN_W-1:WIN_W-2] == 2'b10);
        else if (entering_slot0)
            return win == I2S_ENTER_SLOT0;
        else
            return win == I2S_ENTER_SLOT1;
    endfunction

endpackage

// File: rtl/lsm_bit_sampler.sv
module lsm_bit_sampler
    import lsm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bclk_i,
    input  logic     lrclk_i,
    output lsm_bit_t bit_o
);

    logic bclk_s;
    logic lr_s;
    logic bclk_prev;

    generate
        if (SYNC_STAGES <= 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    bclk_s <= 1'b0;
                    lr_s   <= 1'b0;
                end else begin
                    bclk_s <= bclk_i;
                    lr_s   <= lrclk_i;
                end
            end
        end else begin : g_chain
            logic [SYNC_STAGES-1:0] b_chain;
            logic [SYNC_STAGES-1:0] l_chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    b_chain <= '0;
                    l_chain <= '0;
                end else begin
                    b_chain <= {b_chain[SYNC_STAGES-2:0], bclk_i};
                    l_chain <= {l_chain[SYNC_STAGES-2:0], lrclk_i};
                end
            end
            assign bclk_s = b_chain[SYNC_STAGES-1];
            assign lr_s   = l_chain[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) bclk_prev <= 1'b0;
        else     bclk_prev <= bclk_s;
    end

    always_comb begin
        bit_o.tick = bclk_s & ~bclk_prev;
        bit_o.lr   = lr_s;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        bit_o.tick |=> !bit_o.tick); // R4

endmodule

// File: rtl/lsm_lr_window.sv
module lsm_lr_window
    import lsm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  lsm_bit_t         bit_i,
    output logic [WIN_W-1:0] win_next_o
);

    logic [WIN_W-1:0] win_q;

    // Newest bit lands at the top, older bits move down
    assign win_next_o = {bit_i.lr, win_q[WIN_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst)             win_q <= '0;
        else if (bit_i.tick) win_q <= win_next_o;
    end

    AST_WINDOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !bit_i.tick |=> $stable(win_q)); // R4

    AST_WINDOW_NEWEST: assert property (@(posedge clk) disable iff (rst)
        bit_i.tick |=> (win_q[WIN_W-1] == $past(bit_i.lr))); // R4

endmodule

// File: rtl/lsm_hunter.sv
module lsm_hunter
    import lsm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lsm_bit_t bit_i,
    input  logic     hunting_i,
    input  logic     tdm_mode_i,
    output logic     lock_o
);

    logic [2:0] step_q;
    logic       level_hit;

    // Even steps wait for low, odd steps for high
    assign level_hit = hunting_i && bit_i.tick && (bit_i.lr == step_q[0]);
    assign lock_o    = level_hit && (step_q == hunt_last_step(tdm_mode_i));

    always_ff @(posedge clk) begin
        if (rst || !hunting_i) begin
            step_q <= '0;
        end else if (level_hit) begin
            step_q <= lock_o ? 3'd0 : step_q + 3'd1;
        end
    end

    AST_LOCK_LEVEL: assert property (@(posedge clk) disable iff (rst)
        lock_o |-> (bit_i.lr == tdm_mode_i)); // R2

    AST_LOCK_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        (hunting_i && !bit_i.tick) |=> $stable(step_q)); // R3

endmodule

// File: rtl/lsm_frame_tracker.sv
module lsm_frame_tracker
    import lsm_pkg::*;
#(
    parameter int TDM_SLOTS = 8,
    parameter int SLOT_W    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  lsm_bit_t         bit_i,
    input  logic [WIN_W-1:0] win_next_i,
    input  logic             lock_i,
    input  logic             tdm_mode_i,
    output logic             hunting_o,
    output logic             in_sync_o,
    output logic             sync_err_o,
    output logic [SLOT_W-1:0] slot_o
);

    localparam int BIT_W = $clog2(WIN_W);

    lsm_state_e        state_q;
    logic              mode_q;
    logic [BIT_W-1:0]  bit_q;
    logic [SLOT_W-1:0] slot_q;
    logic              err_q;

    logic [SLOT_W-1:0] last_slot;
    logic [SLOT_W-1:0] slot_nxt;
    logic              boundary;
    logic              fault;

    always_comb begin
        last_slot = mode_q ? SLOT_W'(TDM_SLOTS - 1) : SLOT_W'(1);
        slot_nxt  = (slot_q == last_slot) ? '0 : slot_q + 1'b1;
        boundary  = bit_i.tick && (state_q == ST_RUN) && (bit_q == BIT_W'(WIN_W - 1));
        fault     = boundary && !window_ok(mode_q, slot_nxt == '0, win_next_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            mode_q  <= 1'b0;
            bit_q   <= '0;
            slot_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= fault;
            case (state_q)
                ST_HUNT: begin
                    if (lock_i) begin
                        state_q <= ST_RUN;
                        mode_q  <= tdm_mode_i;
                        bit_q   <= '0;
                        slot_q  <= '0;
                    end
                end
                default: begin
                    if (fault) begin
                        state_q <= ST_HUNT;
                        bit_q   <= '0;
                        slot_q  <= '0;
                    end else if (bit_i.tick) begin
                        bit_q <= bit_q + 1'b1;
                        if (bit_q == BIT_W'(WIN_W - 1))
                            slot_q <= slot_nxt;
                    end
                end
            endcase
        end
    end

    assign hunting_o  = (state_q == ST_HUNT);
    assign in_sync_o  = (state_q == ST_RUN);
    assign sync_err_o = err_q;
    assign slot_o     = slot_q;

    AST_ERR_DROPS_SYNC: assert property (@(posedge clk) disable iff (rst)
        sync_err_o |-> !in_sync_o); // R7

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        sync_err_o |=> !sync_err_o); // R7

    AST_HUNT_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !in_sync_o |-> (slot_o == '0)); // R1

    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        in_sync_o |-> (slot_o <= last_slot)); // R8

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        (in_sync_o && $past(in_sync_o) && (slot_o != $past(slot_o))) |->
        (slot_o == (($past(slot_o) == last_slot) ? {SLOT_W{1'b0}} : $past(slot_o) + 1'b1))); // R8

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (in_sync_o && $past(in_sync_o)) |-> $stable(mode_q)); // R9

endmodule

// File: rtl/lrclk_sync_monitor.sv
module lrclk_sync_monitor
    import lsm_pkg::*;
#(
    parameter int TDM_CHANS   = 8,
    parameter int DATA_LINES  = 1,
    parameter int SYNC_STAGES = 2,
    localparam int TDM_SLOTS  = TDM_CHANS / DATA_LINES,
    localparam int MAX_SLOTS  = (TDM_SLOTS > 2) ? TDM_SLOTS : 2,
    localparam int SLOT_W     = $clog2(MAX_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk_i,
    input  logic              lrclk_i,
    input  logic              tdm_mode_i,
    output logic              in_sync_o,
    output logic              sync_err_o,
    output logic [SLOT_W-1:0] slot_o
);

    lsm_bit_t         bit_s;
    logic [WIN_W-1:0] win_next;
    logic             hunting;
    logic             lock;

    lsm_bit_sampler #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sampler (
        .clk     (clk),
        .rst     (rst),
        .bclk_i  (bclk_i),
        .lrclk_i (lrclk_i),
        .bit_o   (bit_s)
    );

    lsm_lr_window u_window (
        .clk        (clk),
        .rst        (rst),
        .bit_i      (bit_s),
        .win_next_o (win_next)
    );

    lsm_hunter u_hunter (
        .clk        (clk),
        .rst        (rst),
        .bit_i      (bit_s),
        .hunting_i  (hunting),
        .tdm_mode_i (tdm_mode_i),
        .lock_o     (lock)
    );

    lsm_frame_tracker #(
        .TDM_SLOTS (TDM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) u_tracker (
        .clk        (clk),
        .rst        (rst),
        .bit_i      (bit_s),
        .win_next_i (win_next),
        .lock_i     (lock),
        .tdm_mode_i (tdm_mode_i),
        .hunting_o  (hunting),
        .in_sync_o  (in_sync_o),
        .sync_err_o (sync_err_o),
        .slot_o     (slot_o)
    );

endmodule

// File: tb/lrclk_sync_monitor_tb.sv
module lrclk_sync_monitor_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bclk = 1'b0;
    logic       lrclk = 1'b0;
    logic       tdm_mode = 1'b0;
    logic       in_sync;
    logic       sync_err;
    logic [2:0] slot;

    int total = 0;
    int fails = 0;
    int err_count = 0;
    int phase = 0;
    int width = 1;

    always #4 clk = ~clk;   // 125 MHz

    lrclk_sync_monitor u_dut (
        .clk        (clk),
        .rst        (rst),
        .bclk_i     (bclk),
        .lrclk_i    (lrclk),
        .tdm_mode_i (tdm_mode),
        .in_sync_o  (in_sync),
        .sync_err_o (sync_err),
        .slot_o     (slot)
    );

    always @(posedge clk) if (!rst && sync_err) err_count++;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One serial bit: LR set at start of low phase, 4 cycles low, 4 high
    task automatic drive_bit(input logic lr);
        @(negedge clk);
        lrclk = lr;
        bclk  = 1'b0;
        repeat (4) @(negedge clk);
        bclk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic i2s_run(input int n);
        for (int i = 0; i < n; i++) begin
            drive_bit(((phase / 32) % 2) == 1);
            phase++;
        end
    endtask

    task automatic tdm_run(input int n);
        for (int i = 0; i < n; i++) begin
            drive_bit((phase % 256) < width);
            phase++;
        end
    endtask

    task automatic do_reset(input logic mode, input int start_phase);
        @(negedge clk);
        rst = 1'b1;
        bclk = 1'b0;
        lrclk = 1'b0;
        tdm_mode = mode;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        err_count = 0;
        phase = start_phase;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset(1'b0, 0);
        check("R1 in_sync after reset", in_sync, 0);
        check("R1 sync_err after reset", sync_err, 0);
        check("R1 slot after reset", slot, 0);
    endtask

    task automatic t_i2s_lock();
        i2s_run(128);
        check("R2 no lock before final low", in_sync, 0);
        i2s_run(1);
        check("R2 lock on final low", in_sync, 1);
        check("R8 slot 0 at lock", slot, 0);
        i2s_run(31);
        check("R8 slot 0 before first boundary", slot, 0);
        i2s_run(1);
        check("R8 slot 1 after 32 bits", slot, 1);
        i2s_run(32);
        check("R8 I2S slot wraps to 0", slot, 0);
        i2s_run(508);
        check("R5 clean I2S stream has no errors", err_count, 0);
        check("R5 stays locked", in_sync, 1);
    endtask

    task automatic t_mode_ignored();
        tdm_mode = 1'b1;
        i2s_run(300);
        check("R9 mode change while locked: errors", err_count, 0);
        check("R9 mode change while locked: in_sync", in_sync, 1);
        tdm_mode = 1'b0;
    endtask

    task automatic t_i2s_slip();
        while ((phase % 64) != 0) i2s_run(1);
        drive_bit(1'b0);          // extra low bit stretches the left half
        i2s_run(32);
        check("R7 I2S slip gives one error pulse", err_count, 1);
        check("R7 in_sync drops on error", in_sync, 0);
        check("R7 slot back to 0 on error", slot, 0);
        i2s_run(320);
        check("R7 relock after I2S slip", in_sync, 1);
        check("R5 no further errors after relock", err_count, 1);
    endtask

    task automatic t_tdm_lock();
        do_reset(1'b1, 1);
        width = 1;
        tdm_run(767);
        check("R3 no lock before third rising edge", in_sync, 0);
        tdm_run(1);
        check("R3 lock on third rising edge", in_sync, 1);
        check("R8 TDM slot 0 at lock", slot, 0);
        tdm_run(32);
        check("R8 TDM slot 1", slot, 1);
        tdm_run(192);
        check("R8 TDM last slot 7", slot, 7);
        tdm_run(32);
        check("R8 TDM slot wraps to 0", slot, 0);
        tdm_run(1024);
        check("R6 clean TDM stream has no errors", err_count, 0);
        check("R6 TDM stays locked", in_sync, 1);
    endtask

    task automatic t_tdm_falling_free();
        while ((phase % 256) != 0) tdm_run(1);
        width = 100;
        tdm_run(768);
        width = 3;
        tdm_run(768);
        width = 200;
        tdm_run(768);
        check("R6 sync pulse width changes ignored: errors", err_count, 0);
        check("R6 sync pulse width changes ignored: in_sync", in_sync, 1);
    endtask

    task automatic t_tdm_late_edge();
        drive_bit(1'b0);          // rising edge arrives one bit late
        check("R6 late rising edge flagged", err_count, 1);
        check("R7 TDM in_sync drops", in_sync, 0);
        tdm_run(1100);
        check("R3 TDM relock after slip", in_sync, 1);
        check("R7 single error for one slip", err_count, 1);
    endtask

    initial begin
        t_reset_state();
        t_i2s_lock();
        t_mode_ignored();
        t_i2s_slip();
        t_tdm_lock();
        t_tdm_falling_free();
        t_tdm_late_edge();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule